// File: doc/BRIEF.md
# Flash command interface state machine

This block is the bus-facing command logic of a parallel NOR flash device. It samples the chip-enable, write-enable and output-enable strobes, the word address and the data bus on a system clock. It recognises multi-write command sequences and, when a sequence completes, launches a program, sector erase or chip erase job on an embedded engine through a start pulse. The pulse carries the operation code, the address and the data.

While a job runs, the block decides which writes the engine may see. It blocks every write during program and chip erase. During sector erase it passes only the suspend command. Reads during a job return status instead of array data. One bit alternates on every read cycle. Another bit reads as the complement of bit 7 of the data being programmed, or as 0 during an erase. When the engine reports that a job has finished or has been suspended, the decoder returns to array read with the full command set available.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A write cycle (write-enable low then high while chip-enable is low) takes its address from the falling edge of write-enable and its data from the rising edge. If the address or data change while write-enable is low, the job uses the address present at the fall and the data present at the rise.
- R2: The writes AAh to 555h, 55h to 2AAh and A0h to 555h, followed by one more write, give exactly one `job_start` pulse. With that pulse, `job_op` is 01 (program), `job_addr` is the address of the last write and `job_data` is its data. The address compare uses the low 11 address bits.
- R3: If a write breaks a sequence, by wrong data or wrong address, the decoder returns to read mode and no job starts. A write of F0h in read mode or in the middle of a sequence does the same. In the data-write step that follows A0h, every value, F0h included, counts as program data.
- R4: The writes AAh/555h, 55h/2AAh, 80h/555h, AAh/555h and 55h/2AAh, followed by 30h at any address, start a sector erase (`job_op` = 10) with `job_addr` set to the address of that last write. If the last write is instead 10h at 555h, a chip erase starts (`job_op` = 11).
- R5: From the `job_start` pulse until `eng_done`, a program or chip erase job ignores every write. No further `job_start` and no `job_susp` pulse occur.
- R6: During a sector erase, a write of B0h gives one `job_susp` pulse. A second B0h before `eng_done` gives no further pulse. Every other write is ignored.
- R7: An `eng_done` pulse ends the job or the suspend and returns the decoder to read mode. A write whose rising edge is seen in the same cycle as `eng_done` is still judged as arriving during the job, so it is ignored. After that, a complete command sequence is accepted again.
- R8: While a job runs, `dout` shows status. Bit 6 flips on every read cycle (output-enable falling while chip-enable is low), and the first read after a start returns 1. Bit 7 is the complement of bit 7 of `job_data` for a program job and 0 for an erase. All other bits are 0.
- R9: With no job running, `dout` equals `arr_data`.
- R10: After reset no job is active, no pulse is issued and `dout` equals `arr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data: array or status |
| arr_data | input | DW | Array word at the current address |
| job_start | output | 1 | One-cycle job launch pulse |
| job_op | output | 2 | Operation: 01 program, 10 sector erase, 11 chip erase |
| job_addr | output | AW | Address held for the job |
| job_data | output | DW | Data held for the job |
| job_susp | output | 1 | One-cycle erase suspend request |
| eng_done | input | 1 | Engine finished or suspended |

## Verification
The completion pulse from the engine and the rising edge of a bus write can land in the same cycle. The bench times `eng_done` so that it is sampled at the very edge where the write's rising edge is decoded. The write is the first unlock byte of a fresh program sequence. The rest of that sequence must then start nothing, because the first byte was judged as arriving during the job, and a following complete sequence must start a program. A read edge that falls while a job is finishing is judged the same way: status follows the job state held in that cycle.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] arr_data,
  output logic          job_start,
  output logic [1:0]    job_op,
  output logic [AW-1:0] job_addr,
  output logic [DW-1:0] job_data,
  output logic          job_susp,
  input  logic          eng_done
);
  localparam logic [10:0] UNL_A = 11'h555;
  localparam logic [10:0] UNL_B = 11'h2AA;

  typedef enum logic [2:0] {C_RD, C_U1, C_U2, C_PG, C_E0, C_E1, C_E2} cmd_t;
  typedef enum logic [1:0] {J_NONE = 2'd0, J_PG = 2'd1, J_SE = 2'd2, J_CE = 2'd3} job_t;

  logic ce_r, we_r, oe_r, we_q, oe_q;
  logic [AW-1:0] a_r, lat_a;
  logic [DW-1:0] d_r;
  cmd_t cmd, cmd_n;
  job_t job, st_op;
  logic st, sp, susp_req, tog;
  logic [DW-1:0] stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_r <= 1'b1; we_r <= 1'b1; oe_r <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1;
      a_r <= '0; d_r <= '0;
    end else begin
      ce_r <= ce_n; we_r <= we_n; oe_r <= oe_n; we_q <= we_r; oe_q <= oe_r;
      a_r <= addr; d_r <= din;
    end

  wire we_fall = we_q & ~we_r & ~ce_r;
  wire wr_ev   = ~we_q & we_r & ~ce_r;
  wire rd_ev   = oe_q & ~oe_r & ~ce_r;
  wire [7:0] cb = d_r[7:0];
  wire at_a = lat_a[10:0] == UNL_A;
  wire at_b = lat_a[10:0] == UNL_B;
  wire busy = job != J_NONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_a <= '0;
    else if (we_fall) lat_a <= a_r;

  always_comb begin
    cmd_n = cmd;
    st = 1'b0;
    st_op = J_NONE;
    if (!busy && wr_ev) begin
      if (cmd != C_PG && cb == 8'hF0) cmd_n = C_RD;
      else case (cmd)
        C_RD: cmd_n = (at_a && cb == 8'hAA) ? C_U1 : C_RD;
        C_U1: cmd_n = (at_b && cb == 8'h55) ? C_U2 : C_RD;
        C_U2: cmd_n = (at_a && cb == 8'hA0) ? C_PG :
                      (at_a && cb == 8'h80) ? C_E0 : C_RD;
        C_PG: begin cmd_n = C_RD; st = 1'b1; st_op = J_PG; end
        C_E0: cmd_n = (at_a && cb == 8'hAA) ? C_E1 : C_RD;
        C_E1: cmd_n = (at_b && cb == 8'h55) ? C_E2 : C_RD;
        C_E2: begin
          cmd_n = C_RD;
          if (cb == 8'h30) begin st = 1'b1; st_op = J_SE; end
          else if (at_a && cb == 8'h10) begin st = 1'b1; st_op = J_CE; end
        end
        default: cmd_n = C_RD;
      endcase
    end
  end

  assign sp = wr_ev && job == J_SE && !susp_req && cb == 8'hB0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd <= C_RD; job <= J_NONE; susp_req <= 1'b0; tog <= 1'b0;
      job_start <= 1'b0; job_susp <= 1'b0; job_op <= 2'd0;
      job_addr <= '0; job_data <= '0;
    end else if (eng_done) begin
      cmd <= C_RD; job <= J_NONE; susp_req <= 1'b0;
      job_start <= 1'b0; job_susp <= 1'b0;
    end else begin
      cmd <= cmd_n;
      job_start <= st;
      job_susp <= sp;
      if (sp) susp_req <= 1'b1;
      if (busy && rd_ev) tog <= ~tog;
      if (st) begin
        job <= st_op; job_op <= st_op; job_addr <= lat_a; job_data <= d_r; tog <= 1'b0;
      end
    end

  always_comb begin
    stat = '0;
    stat[7] = (job == J_PG) ? ~job_data[7] : 1'b0;
    stat[6] = tog;
  end
  assign dout = busy ? stat : arr_data;

  // R5
  locked_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job == J_PG || job == J_CE) |=> !job_start && !job_susp);
  // R6
  susp_only_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_susp |-> $past(job) == J_SE);
  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> $past(job) == J_NONE && job != J_NONE);
  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_start, job_susp}));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> job == J_NONE && !job_start && !job_susp);
  // R8
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_ev && !eng_done) |=> busy && dout[6] != $past(dout[6]));
endmodule

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int AW = 16;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, eng_done = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, arr_data;
  logic job_start, job_susp;
  logic [1:0] job_op;
  logic [AW-1:0] job_addr;
  logic [DW-1:0] job_data;
  int errs = 0, checks = 0, nstart = 0, nsusp = 0;
  logic [DW-1:0] v;

  always #10 clk = ~clk;
  assign arr_data = addr[7:0] ^ 8'h3C;

  flash_cmd_fsm #(.AW(AW), .DW(DW)) dut (.*);

  always @(posedge clk) begin
    if (job_start) nstart <= nstart + 1;
    if (job_susp) nsusp <= nsusp + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_x(input logic [AW-1:0] a0, a1, input logic [7:0] d0, d1);
    addr = a0; din = d0;
    @(negedge clk) we_n = 0;
    repeat (3) @(negedge clk);
    addr = a1; din = d1;
    repeat (3) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_x(a, a, d, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q);
    addr = a;
    @(negedge clk) oe_n = 0;
    repeat (4) @(negedge clk);
    q = dout;
    oe_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk) eng_done = 1;
    @(negedge clk) eng_done = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int s0, p0;
    logic [AW-1:0] sa [5];
    logic [7:0] sd [5];
    sa[0] = 16'h0555; sd[0] = 8'hAA; sa[1] = 16'h02AA; sd[1] = 8'h55;
    sa[2] = 16'h0555; sd[2] = 8'h80; sa[3] = 16'h0555; sd[3] = 8'hAA;
    sa[4] = 16'h02AA; sd[4] = 8'h55;
    repeat (3) @(negedge clk);
    rst_n = 1; ce_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dout", dout, 8'h3C);
    chk("R10 start", nstart, 0);
    // R9 array read sweep
    for (int a = 0; a < 256; a++) begin
      rd(a[AW-1:0], v);
      chk("R9 array", v, a[7:0] ^ 8'h3C);
    end
    // R2 program with R1 latch timing
    unlock(); wr(16'h0555, 8'hA0);
    wr_x(16'h0123, 16'h0456, 8'h11, 8'h5A);
    chk("R2 start", nstart, 1);
    chk("R2 op", job_op, 2'b01);
    chk("R1 addr", job_addr, 16'h0123);
    chk("R1 data", job_data, 8'h5A);
    // R8 program status
    for (int i = 0; i < 4; i++) begin
      rd(16'h0010, v);
      chk("R8 pgm status", v, {1'b1, ~i[0], 6'b0});
    end
    // R5 all data values ignored while programming
    for (int d = 0; d < 256; d++) wr(16'h0555, d[7:0]);
    chk("R5 no start", nstart, 1);
    chk("R5 no susp", nsusp, 0);
    rd(16'h0010, v);
    chk("R5 still busy", v[7], 1'b1);
    chk("R5 status low", v[5:0], 6'd0);
    done_pulse();
    rd(16'h0021, v);
    chk("R7 read mode", v, 8'h21 ^ 8'h3C);
    // R3 broken sequences, wrong data and wrong address
    s0 = nstart;
    for (int p = 0; p < 5; p++)
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 5; k++)
          if (k == p) wr(m ? sa[k] ^ 16'h0001 : sa[k], m ? sd[k] : sd[k] ^ 8'h01);
          else wr(sa[k], sd[k]);
        wr(16'h0040, 8'h30);
        chk("R3 broken", nstart, s0);
        rd(16'h0007, v);
        chk("R3 read mode", v, 8'h07 ^ 8'h3C);
      end
    // R3 reset word mid-sequence
    unlock(); wr(16'h0555, 8'hF0); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h77);
    chk("R3 reset word", nstart, s0);
    wr(16'h0555, 8'hAA); wr(16'h0555, 8'hF0); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h77);
    chk("R3 reset word U1", nstart, s0);
    // R3 program data of F0h is accepted
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0200, 8'hF0);
    chk("R3 F0 data start", nstart, s0 + 1);
    chk("R3 F0 data", job_data, 8'hF0);
    rd(16'h0000, v);
    chk("R8 pgm F0 status", v, 8'h40);
    done_pulse();
    // R4 sector erase
    for (int k = 0; k < 5; k++) wr(sa[k], sd[k]);
    wr(16'h07C0, 8'h30);
    chk("R4 se start", nstart, s0 + 2);
    chk("R4 se op", job_op, 2'b10);
    chk("R4 se addr", job_addr, 16'h07C0);
    rd(16'h0000, v);
    chk("R8 erase status 1", v, 8'h40);
    rd(16'h0000, v);
    chk("R8 erase status 2", v, 8'h00);
    // R6 sweep: only B0h suspends
    for (int d = 0; d < 256; d++) if (d != 8'hB0) wr(16'h0555, d[7:0]);
    chk("R6 no start", nstart, s0 + 2);
    chk("R6 no susp", nsusp, 0);
    wr(16'h0000, 8'hB0);
    chk("R6 susp", nsusp, 1);
    wr(16'h0000, 8'hB0);
    chk("R6 susp once", nsusp, 1);
    done_pulse();
    rd(16'h0033, v);
    chk("R7 after suspend", v, 8'h33 ^ 8'h3C);
    // R4 chip erase, R6 suspend ignored in chip erase
    for (int k = 0; k < 5; k++) wr(sa[k], sd[k]);
    wr(16'h0555, 8'h10);
    chk("R4 ce start", nstart, s0 + 3);
    chk("R4 ce op", job_op, 2'b11);
    wr(16'h0000, 8'hB0);
    chk("R6 ce no susp", nsusp, 1);
    done_pulse();
    // R7 write coinciding with eng_done
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0300, 8'h12);
    p0 = nstart;
    addr = 16'h0555; din = 8'hAA;
    @(negedge clk) we_n = 0;
    repeat (5) @(negedge clk);
    we_n = 1;
    @(negedge clk) eng_done = 1;
    @(negedge clk) eng_done = 0;
    repeat (3) @(negedge clk);
    wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0301, 8'h34);
    chk("R7 coincident ignored", nstart, p0);
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0302, 8'h56);
    chk("R7 full set again", nstart, p0 + 1);
    chk("R7 data", job_data, 8'h56);
    done_pulse();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule